// File: doc/BRIEF.md
# Real-Time Clock Timebase and Square-Wave/Interrupt Controller

This block sits at the base of a real-time clock. It takes a slow reference clock input (32768, 8192, 60 or 50 Hz, chosen by a control field), samples it with the faster system clock and counts its rising edges. From that count it makes a one-second tick for the calendar counters. The same count, or a pair of alarm flags, drives one shared output pin. In square-wave mode the pin carries a selectable waveform. In interrupt mode it is an active-low alarm request.

Software controls the block through one 8-bit control byte, which it writes and reads back. The byte holds a run enable, the reference-frequency select, the square-wave rate select, the interrupt-mode bit and two alarm enables. A two-state machine, HALT and RUN, governs the divider. The START transition (HALT to RUN) fires on a write with the run bit set. The STOP transition (RUN to HALT) fires on a write with the run bit clear. Any other write leaves the state where it is. In HALT the divider sits at zero. To resynchronise the time, software stops the divider, loads the time and starts it again; the first tick then comes exactly one second of reference edges later. A write that changes the frequency select also restarts the count.

Top module: `rtc_timebase`

## Requirements
- R1: After reset the control byte reads 0x98. Bit 7 = run enable (1), bits 6:5 = frequency select (00), bits 4:3 = rate (11), bit 2 = interrupt mode (0), bit 1 = alarm-2 enable (0), bit 0 = alarm-1 enable (0).
- R2: While the run bit is 0, the divider is held at zero and no tick is produced. After a write that sets the run bit, the first tick follows exactly the N-th detected reference rising edge, where N is the selected edges-per-second.
- R3: Frequency select 00, 01, 10 and 11 give N = 32768, 8192, 60 and 50 reference rising edges per tick.
- R4: `tick_1hz` is high for exactly one system-clock cycle per second.
- R5: With interrupt mode 0 and frequency select 00, the pin follows the divider count c (0..32767). Rate 00 gives 1 Hz (high when c >= 16384). Rate 01 gives c bit 4 (1.024 kHz). Rate 10 gives c bit 2 (4.096 kHz). Rate 11 gives c bit 1 (8.192 kHz).
- R6: With interrupt mode 0 and a nonzero frequency select, the pin carries the 1 Hz square wave (high when c >= N/2) for every rate value.
- R7: With interrupt mode 1, the pin is low exactly when (alarm1 flag AND bit 0) OR (alarm2 flag AND bit 1). With interrupt mode 0, the alarm flags have no effect on the pin.
- R8: A write that changes the frequency select clears the divider. A write that leaves the select unchanged, with the run bit still 1, does not disturb the count.
- R9: When a clearing write and a detected reference edge fall in the same cycle, the clear wins and the edge is not counted.
- R10: A written control byte reads back unchanged on `ctrl_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than four times the reference |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_we | input | 1 | Control byte write strobe |
| ctrl_wdata | input | 8 | Control byte write data |
| ctrl_rdata | output | 8 | Current control byte |
| ref_clk_in | input | 1 | Asynchronous reference clock input |
| alarm1_flag | input | 1 | Alarm 1 match flag |
| alarm2_flag | input | 1 | Alarm 2 match flag |
| tick_1hz | output | 1 | One-cycle pulse once per second |
| sqw_int_n | output | 1 | Shared square-wave / active-low interrupt pin |

## Verification
A control write that clears the divider and a synchronised reference edge that advances it can land in the same system-clock cycle. The bench provokes this on purpose. It raises the reference, waits until the edge detector is about to fire, and times a frequency-select write to be sampled on that same edge. It then judges the result by counting reference edges up to the next tick. If the clear won, the tick comes after exactly N further edges; one edge fewer means the coincident edge was wrongly counted.

// File: rtl/rtc_tb_pkg.sv
package rtc_tb_pkg;

    typedef enum logic {
        TB_HALT = 1'b0,
        TB_RUN  = 1'b1
    } tb_state_e;

    typedef struct packed {
        logic       eclk;
        logic [1:0] clksel;
        logic [1:0] rate;
        logic       intcn;
        logic       a2_ie;
        logic       a1_ie;
    } tb_ctrl_t;

    localparam logic [7:0] CTRL_RESET = 8'h98;

endpackage

// File: rtl/ref_edge_sync.sv
module ref_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    logic [STAGES-1:0] chain;
    logic              last;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= 1'b0;
                    else        chain[0] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[g] <= 1'b0;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last <= 1'b0;
        else        last <= chain[STAGES-1];
    end

    assign rise = chain[STAGES-1] & ~last;

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise); // R4
endmodule

// File: rtl/tb_divider.sv
module tb_divider #(
    parameter int DIV0  = 32768,
    parameter int DIV1  = 8192,
    parameter int DIV2  = 60,
    parameter int DIV3  = 50,
    parameter int CNT_W = $clog2(DIV0)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clr,
    input  logic             rise,
    input  logic [1:0]       sel,
    output logic [CNT_W-1:0] cnt,
    output logic             sec_sq,
    output logic             tick
);
    logic [CNT_W-1:0] lim;
    logic [CNT_W-1:0] half;
    logic             wrap;

    always_comb begin
        unique case (sel)
            2'd0:    begin lim = CNT_W'(DIV0 - 1); half = CNT_W'(DIV0 / 2); end
            2'd1:    begin lim = CNT_W'(DIV1 - 1); half = CNT_W'(DIV1 / 2); end
            2'd2:    begin lim = CNT_W'(DIV2 - 1); half = CNT_W'(DIV2 / 2); end
            default: begin lim = CNT_W'(DIV3 - 1); half = CNT_W'(DIV3 / 2); end
        endcase
    end

    assign wrap   = run && !clr && rise && (cnt == lim);
    assign sec_sq = (cnt >= half);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else begin
            tick <= wrap;
            if (!run || clr)  cnt <= '0;
            else if (wrap)    cnt <= '0;
            else if (rise)    cnt <= cnt + 1'b1;
        end
    end

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= lim || $past(clr)); // R3
    AST_HALT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> cnt == '0); // R2
    AST_TICK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R4
    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> cnt == '0 && !tick); // R9
endmodule

// File: rtl/tb_out_mux.sv
module tb_out_mux
    import rtc_tb_pkg::*;
#(
    parameter int CNT_W  = 15,
    parameter int TAP_1K = 4,
    parameter int TAP_4K = 2,
    parameter int TAP_8K = 1
) (
    input  tb_ctrl_t         ctrl,
    input  logic [CNT_W-1:0] cnt,
    input  logic             sec_sq,
    input  logic             a1f,
    input  logic             a2f,
    output logic             pin
);
    logic irq;
    logic sq;

    assign irq = (a1f & ctrl.a1_ie) | (a2f & ctrl.a2_ie);

    always_comb begin
        if (ctrl.clksel != 2'b00) begin
            sq = sec_sq;
        end else begin
            unique case (ctrl.rate)
                2'b00:   sq = sec_sq;
                2'b01:   sq = cnt[TAP_1K];
                2'b10:   sq = cnt[TAP_4K];
                default: sq = cnt[TAP_8K];
            endcase
        end
        pin = ctrl.intcn ? ~irq : sq;
    end
endmodule

// File: rtl/rtc_timebase.sv
module rtc_timebase
    import rtc_tb_pkg::*;
#(
    parameter int DIV0        = 32768,
    parameter int DIV1        = 8192,
    parameter int DIV2        = 60,
    parameter int DIV3        = 50,
    parameter int SYNC_STAGES = 2,
    parameter int SQ_1K       = 1024,
    parameter int SQ_4K       = 4096,
    parameter int SQ_8K       = 8192
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctrl_we,
    input  logic [7:0] ctrl_wdata,
    output logic [7:0] ctrl_rdata,
    input  logic       ref_clk_in,
    input  logic       alarm1_flag,
    input  logic       alarm2_flag,
    output logic       tick_1hz,
    output logic       sqw_int_n
);
    localparam int CNT_W  = $clog2(DIV0);
    localparam int TAP_1K = $clog2(DIV0 / SQ_1K) - 1;
    localparam int TAP_4K = $clog2(DIV0 / SQ_4K) - 1;
    localparam int TAP_8K = $clog2(DIV0 / SQ_8K) - 1;

    tb_ctrl_t         ctrl;
    tb_ctrl_t         wr_ctrl;
    tb_state_e        state;
    tb_state_e        state_nx;
    logic             rise;
    logic             clr;
    logic             run;
    logic [CNT_W-1:0] cnt;
    logic             sec_sq;

    assign wr_ctrl = tb_ctrl_t'(ctrl_wdata);

    // control byte
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ctrl <= tb_ctrl_t'(CTRL_RESET);
        else if (ctrl_we) ctrl <= wr_ctrl;
    end
    assign ctrl_rdata = ctrl;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= TB_RUN;
        else        state <= state_nx;
    end

    // next state and divider controls
    always_comb begin
        state_nx = state;
        clr      = 1'b0;
        unique case (state)
            TB_HALT: begin
                if (ctrl_we && wr_ctrl.eclk) state_nx = TB_RUN;   // START
                clr = 1'b1;
            end
            TB_RUN: begin
                if (ctrl_we && !wr_ctrl.eclk) state_nx = TB_HALT; // STOP
                if (ctrl_we && (!wr_ctrl.eclk || wr_ctrl.clksel != ctrl.clksel))
                    clr = 1'b1;
            end
            default: state_nx = TB_HALT;
        endcase
    end
    assign run = (state == TB_RUN);

    ref_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (ref_clk_in),
        .rise     (rise)
    );

    tb_divider #(
        .DIV0 (DIV0), .DIV1 (DIV1), .DIV2 (DIV2), .DIV3 (DIV3), .CNT_W (CNT_W)
    ) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .clr    (clr),
        .rise   (rise),
        .sel    (ctrl.clksel),
        .cnt    (cnt),
        .sec_sq (sec_sq),
        .tick   (tick_1hz)
    );

    tb_out_mux #(
        .CNT_W (CNT_W), .TAP_1K (TAP_1K), .TAP_4K (TAP_4K), .TAP_8K (TAP_8K)
    ) u_mux (
        .ctrl   (ctrl),
        .cnt    (cnt),
        .sec_sq (sec_sq),
        .a1f    (alarm1_flag),
        .a2f    (alarm2_flag),
        .pin    (sqw_int_n)
    );

    AST_STATE_FOLLOWS_ECLK: assert property (@(posedge clk) disable iff (!rst_n)
        run == ctrl.eclk); // R2
    AST_HALT_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !tick_1hz); // R2
    AST_INT_ASSERTED: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.intcn && ((alarm1_flag && ctrl.a1_ie) || (alarm2_flag && ctrl.a2_ie)))
        |-> !sqw_int_n); // R7
    AST_INT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.intcn && !(alarm1_flag && ctrl.a1_ie) && !(alarm2_flag && ctrl.a2_ie))
        |-> sqw_int_n); // R7
    AST_WRITE_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_we |=> ctrl_rdata == $past(ctrl_wdata)); // R10
endmodule

// File: tb/rtc_timebase_test.sv
module rtc_timebase_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    // {ctrl[7:0], alarm1, alarm2, expected pin}
    localparam logic [10:0] VEC [8] = '{
        {8'h04, 1'b1, 1'b0, 1'b1},
        {8'h05, 1'b1, 1'b0, 1'b0},
        {8'h05, 1'b0, 1'b1, 1'b1},
        {8'h06, 1'b0, 1'b1, 1'b0},
        {8'h07, 1'b1, 1'b1, 1'b0},
        {8'h07, 1'b0, 1'b0, 1'b1},
        {8'h03, 1'b1, 1'b1, 1'b0},
        {8'h07, 1'b1, 1'b0, 1'b0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctrl_we = 1'b0;
    logic [7:0] ctrl_wdata = 8'h00;
    logic [7:0] ctrl_rdata;
    logic       ref_clk_in = 1'b0;
    logic       alarm1_flag = 1'b0;
    logic       alarm2_flag = 1'b0;
    logic       tick_1hz;
    logic       sqw_int_n;

    int applied = 0;
    int bad = 0;
    int ticks = 0;
    int dbl = 0;
    logic tick_q = 1'b0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rtc_timebase uut (
        .clk (clk), .rst_n (rst_n), .ctrl_we (ctrl_we), .ctrl_wdata (ctrl_wdata),
        .ctrl_rdata (ctrl_rdata), .ref_clk_in (ref_clk_in),
        .alarm1_flag (alarm1_flag), .alarm2_flag (alarm2_flag),
        .tick_1hz (tick_1hz), .sqw_int_n (sqw_int_n)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        tick_q <= tick_1hz;
        if (tick_1hz) ticks <= ticks + 1;
        if (tick_1hz && tick_q) dbl <= dbl + 1;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        applied++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk);
        ctrl_we = 1'b1;
        ctrl_wdata = d;
        @(negedge clk);
        ctrl_we = 1'b0;
    endtask

    task automatic pulse(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ref_clk_in = 1'b1;
            @(negedge clk);
            ref_clk_in = 1'b0;
        end
    endtask

    task automatic settle();
        repeat (5) @(negedge clk);
    endtask

    // restart in mode d from zero, expect first tick after exactly n edges
    task automatic sec_check(input logic [7:0] d, input int n, input string req);
        int t0;
        wr(d & 8'h7F);
        wr(d);
        t0 = ticks;
        pulse(n - 1);
        settle();
        check(ticks == t0, req, ticks - t0, 0);
        pulse(1);
        settle();
        check(ticks == t0 + 1, req, ticks - t0, 1);
    endtask

    initial begin
        int t0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(ctrl_rdata == 8'h98, "R1", ctrl_rdata, 8'h98);
        check(tick_1hz == 1'b0, "R1", tick_1hz, 0);

        // R7 table walk; R10 readback on each write
        foreach (VEC[i]) begin
            wr(VEC[i][10:3]);
            alarm1_flag = VEC[i][2];
            alarm2_flag = VEC[i][1];
            @(negedge clk);
            check(ctrl_rdata == VEC[i][10:3], "R10", ctrl_rdata, VEC[i][10:3]);
            check(sqw_int_n == VEC[i][0], "R7", sqw_int_n, VEC[i][0]);
        end
        alarm1_flag = 1'b0;
        alarm2_flag = 1'b0;

        // R2 halted: edges produce no tick
        wr(8'h00);
        t0 = ticks;
        pulse(70);
        settle();
        check(ticks == t0, "R2", ticks - t0, 0);

        // R3 every divide ratio, R2 restart alignment
        sec_check(8'hC0, 60, "R3");
        sec_check(8'hE0, 50, "R3");
        sec_check(8'hA0, 8192, "R3");
        sec_check(8'h80, 32768, "R2");

        // R5 taps with select 00
        wr(8'h08); wr(8'h88);
        pulse(15); settle();
        check(sqw_int_n == 1'b0, "R5", sqw_int_n, 0);
        pulse(1); settle();
        check(sqw_int_n == 1'b1, "R5", sqw_int_n, 1);
        wr(8'h10); wr(8'h90);
        pulse(3); settle();
        check(sqw_int_n == 1'b0, "R5", sqw_int_n, 0);
        pulse(1); settle();
        check(sqw_int_n == 1'b1, "R5", sqw_int_n, 1);
        wr(8'h18); wr(8'h98);
        pulse(1); settle();
        check(sqw_int_n == 1'b0, "R5", sqw_int_n, 0);
        pulse(1); settle();
        check(sqw_int_n == 1'b1, "R5", sqw_int_n, 1);
        wr(8'h00); wr(8'h80);
        pulse(16383); settle();
        check(sqw_int_n == 1'b0, "R5", sqw_int_n, 0);
        pulse(1); settle();
        check(sqw_int_n == 1'b1, "R5", sqw_int_n, 1);

        // R6 nonzero select: 1 Hz regardless of rate
        wr(8'h58); wr(8'hD8);
        pulse(27); settle();
        check(sqw_int_n == 1'b0, "R6", sqw_int_n, 0);
        pulse(3); settle();
        check(sqw_int_n == 1'b1, "R6", sqw_int_n, 1);

        // R8 select change clears the count
        wr(8'h40); wr(8'hC0);
        pulse(30);
        wr(8'hE0);
        t0 = ticks;
        pulse(49); settle();
        check(ticks == t0, "R8", ticks - t0, 0);
        pulse(1); settle();
        check(ticks == t0 + 1, "R8", ticks - t0, 1);
        // R8 unchanged select keeps the count
        t0 = ticks;
        pulse(20);
        wr(8'hE4);
        pulse(29); settle();
        check(ticks == t0, "R8", ticks - t0, 0);
        pulse(1); settle();
        check(ticks == t0 + 1, "R8", ticks - t0, 1);

        // R9 write coincides with a detected edge
        wr(8'h60); wr(8'hE0);
        pulse(10);
        @(negedge clk);
        ref_clk_in = 1'b1;
        @(negedge clk);
        ref_clk_in = 1'b0;
        @(negedge clk);
        ctrl_we = 1'b1;
        ctrl_wdata = 8'hC0;
        @(negedge clk);
        ctrl_we = 1'b0;
        t0 = ticks;
        pulse(59); settle();
        check(ticks == t0, "R9", ticks - t0, 0);
        pulse(1); settle();
        check(ticks == t0 + 1, "R9", ticks - t0, 1);

        // R4 no tick ever wider than one cycle
        check(dbl == 0, "R4", dbl, 0);

        $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
        $finish;
    end

    initial begin
        wait (cycles >= WATCHDOG);
        applied++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, WATCHDOG);
        $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
        $finish;
    end
endmodule